// File: doc/BRIEF.md
# Set-Associative L1 Data Cache

This block is a parameterised set-associative data cache placed between a processor and the next memory level. Both sides use one handshake: the initiator raises a request line with a write flag (0 for a load, 1 for a store), an address and, for stores, data. The responder answers with an acknowledge. The processor side carries one data word per transfer. The memory side carries half a cache line per beat, so a line moves in two beats.

A load or store that hits is done in the lookup cycle. A miss picks a victim way in the addressed set. If that line is valid and modified, it is first written out in full to the next level. The requested line is then fetched, and the lookup is repeated, so it now hits and completes the access. Stores that miss allocate the line in the same way before the word is written. The victim policy is chosen at elaboration: fill order, least recently used, or pseudo-random. Activity counters give accesses, hits, misses, line fills and line write-backs for energy estimation.

Top module: `l1_cache`

## Requirements
- R1: After reset, cpu_ack and mem_req are low, all five counters read zero, and every line is invalid.
- R2: A load or store to a resident line raises cpu_ack one clock after the request is first sampled. cpu_ack stays high for exactly one clock, and a load returns the stored word on cpu_rdata while cpu_ack is high.
- R3: A load miss to a set with a clean or invalid victim fetches the line in two beats with mem_we low. The beat addresses are {tag, set, beat} with beat 0 first, and the lower half of mem_rdata holds the lower-addressed word. cpu_ack follows four clocks after the request and carries the memory word.
- R4: A store hit updates only the addressed word and marks its line modified. A later load of that word returns the stored value.
- R5: A store miss allocates the line: it fetches the line, writes the word, and acknowledges four clocks after the request.
- R6: When the victim line is valid and modified, both halves are written to the next level (mem_we high, address {old tag, set, beat}) before the fetch. cpu_ack follows six clocks after the request, and the next level then holds the modified data.
- R7: A clean victim is dropped without any memory write.
- R8: An invalid way is filled before any valid way is replaced, lowest way first. With the default least-recently-used policy, the victim is the way whose last hit or fill lies furthest back.
- R9: While the processor keeps cpu_req high after an acknowledge, no further acknowledge is given. A new access is taken only after cpu_req has been low for a sampled clock edge.
- R10: cnt_access counts each processor access once, and cnt_hit + cnt_miss always equals cnt_access. cnt_fill counts fetched lines and cnt_wb counts written-back lines; the repeated lookup after a fill is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor access request, held until acknowledge |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address {tag, set, word} |
| cpu_wdata | input | DW | Store data |
| cpu_rdata | output | DW | Load data, valid with cpu_ack |
| cpu_ack | output | 1 | One-clock completion pulse |
| mem_req | output | 1 | Next-level request, one per beat |
| mem_we | output | 1 | 1 = write-back beat, 0 = fetch beat |
| mem_addr | output | MADDR_W | Beat address {tag, set, beat} |
| mem_wdata | output | MW | Write-back beat data |
| mem_rdata | input | MW | Fetched beat data |
| mem_ack | input | 1 | Next level accepts the beat |
| cnt_access | output | CNT_W | Processor accesses |
| cnt_hit | output | CNT_W | First-lookup hits |
| cnt_miss | output | CNT_W | First-lookup misses |
| cnt_fill | output | CNT_W | Lines fetched |
| cnt_wb | output | CNT_W | Lines written back |

## Verification
Each result has a fixed due cycle, counted from the clock edge that first samples the request. A hit acknowledges after one edge. A clean miss acknowledges after four edges: the lookup, two fetch beats and the repeated lookup. A dirty miss adds two write-back beats, for six edges. The bench drives the request on a falling edge, counts the rising edges up to the acknowledge, and compares that count with the latency expected for the hit, clean-miss or dirty-miss case, sampling cpu_rdata and the counters in the low phase after each edge. It also checks in the following low phase that the acknowledge has dropped, and it reads the write-back contents out of its memory model once the access has completed.

// File: rtl/l1_cache_pkg.sv
package l1_cache_pkg;
    typedef enum logic [1:0] {
        REPL_FIFO   = 2'd0,
        REPL_LRU    = 2'd1,
        REPL_RANDOM = 2'd2
    } repl_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WB   = 2'd1,
        ST_FILL = 2'd2,
        ST_HOLD = 2'd3
    } ctl_st_e;
endpackage

// File: rtl/l1_way.sv
// One way: tag, valid, dirty and data storage for every set, with its comparator.
module l1_way #(
    parameter int DW    = 32,
    parameter int WORDS = 4,
    parameter int SETS  = 4,
    parameter int TAG_W = 6,
    parameter int BEATS = 2,
    localparam int IDX_W  = $clog2(SETS),
    localparam int OFF_W  = $clog2(WORDS),
    localparam int WPB    = WORDS / BEATS,
    localparam int MW     = WPB * DW,
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    set_i,
    input  logic [TAG_W-1:0]    tag_i,
    output logic                hit_o,
    output logic                valid_o,
    output logic                dirty_o,
    output logic [TAG_W-1:0]    tag_o,
    output logic [WORDS*DW-1:0] line_o,
    input  logic                wr_en_i,
    input  logic [OFF_W-1:0]    wr_word_i,
    input  logic [DW-1:0]       wr_data_i,
    input  logic                fill_en_i,
    input  logic [BEAT_W-1:0]   fill_beat_i,
    input  logic [MW-1:0]       fill_data_i,
    input  logic                fill_last_i
);
    logic [DW-1:0]    data_q [SETS][WORDS];
    logic [TAG_W-1:0] tag_q  [SETS];
    logic [SETS-1:0]  valid_q, valid_d;
    logic [SETS-1:0]  dirty_q, dirty_d;

    assign valid_o = valid_q[set_i];
    assign dirty_o = dirty_q[set_i];
    assign tag_o   = tag_q[set_i];
    assign hit_o   = valid_q[set_i] && (tag_q[set_i] == tag_i);

    for (genvar w = 0; w < WORDS; w++) begin : g_line
        assign line_o[w*DW +: DW] = data_q[set_i][w];
    end

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        if (wr_en_i) dirty_d[set_i] = 1'b1;
        if (fill_en_i && fill_last_i) begin
            valid_d[set_i] = 1'b1;
            dirty_d[set_i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en_i) data_q[set_i][wr_word_i] <= wr_data_i;
        if (fill_en_i) begin
            for (int k = 0; k < WPB; k++)
                data_q[set_i][OFF_W'(int'(fill_beat_i) * WPB + k)] <= fill_data_i[k*DW +: DW];
            if (fill_last_i) tag_q[set_i] <= tag_i;
        end
    end

    // R4: a store to this way leaves its line marked modified
    a_r4_write_marks_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> dirty_q[$past(set_i)]);
endmodule

// File: rtl/l1_repl.sv
// Victim selection per set: invalid way first, then the elaborated policy.
module l1_repl #(
    parameter int                  SETS = 4,
    parameter int                  WAYS = 2,
    parameter l1_cache_pkg::repl_e REPL = l1_cache_pkg::REPL_LRU,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] set_i,
    input  logic [WAYS-1:0]  valid_i,
    input  logic             touch_i,
    input  logic [WAY_W-1:0] touch_way_i,
    input  logic             fill_i,
    output logic [WAY_W-1:0] victim_o
);
    logic [WAY_W-1:0] base;

    if (REPL == l1_cache_pkg::REPL_LRU) begin : g_lru
        logic [WAY_W-1:0] age_q [SETS][WAYS];
        logic [WAY_W-1:0] age_d [SETS][WAYS];
        logic [WAYS-1:0]  oldest;
        logic             unused_fill;
        assign unused_fill = fill_i;

        always_comb begin
            age_d = age_q;
            if (touch_i) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == touch_way_i)
                        age_d[set_i][w] = '0;
                    else if (age_q[set_i][w] < age_q[set_i][touch_way_i])
                        age_d[set_i][w] = age_q[set_i][w] + 1'b1;
                end
            end
            base = '0;
            for (int w = 0; w < WAYS; w++) begin
                oldest[w] = (age_q[set_i][w] == WAY_W'(WAYS - 1));
                if (oldest[w]) base = WAY_W'(w);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++)
                    for (int w = 0; w < WAYS; w++)
                        age_q[s][w] <= WAY_W'(w);
            end else begin
                age_q <= age_d;
            end
        end

        // R8: the ages of a set stay a permutation, so exactly one way is oldest
        a_r8_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(oldest) == 1);
    end else if (REPL == l1_cache_pkg::REPL_FIFO) begin : g_fifo
        logic [WAY_W-1:0] ptr_q [SETS];
        logic [WAY_W-1:0] ptr_d [SETS];
        logic             unused_touch;
        assign unused_touch = touch_i ^ (^touch_way_i);

        always_comb begin
            ptr_d = ptr_q;
            if (fill_i) ptr_d[set_i] = ptr_q[set_i] + 1'b1;
            base = ptr_q[set_i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
            end else begin
                ptr_q <= ptr_d;
            end
        end
    end else begin : g_rand
        logic [7:0] lfsr_q, lfsr_d;
        logic       unused_ctl;
        assign unused_ctl = touch_i ^ fill_i ^ (^touch_way_i);

        always_comb begin
            lfsr_d = {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
            base   = lfsr_q[WAY_W-1:0];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lfsr_q <= 8'h5A;
            else        lfsr_q <= lfsr_d;
        end
    end

    always_comb begin
        victim_o = base;
        for (int w = WAYS - 1; w >= 0; w--)
            if (!valid_i[w]) victim_o = WAY_W'(w);
    end
endmodule

// File: rtl/l1_cache.sv
module l1_cache #(
    parameter int                  ADDR_W = 10,
    parameter int                  DW     = 32,
    parameter int                  WORDS  = 4,
    parameter int                  SETS   = 4,
    parameter int                  WAYS   = 2,
    parameter int                  BEATS  = 2,
    parameter int                  CNT_W  = 16,
    parameter l1_cache_pkg::repl_e REPL   = l1_cache_pkg::REPL_LRU,
    localparam int OFF_W   = $clog2(WORDS),
    localparam int IDX_W   = $clog2(SETS),
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
    localparam int WAY_W   = $clog2(WAYS),
    localparam int BEAT_W  = $clog2(BEATS),
    localparam int WPB     = WORDS / BEATS,
    localparam int MW      = WPB * DW,
    localparam int MADDR_W = TAG_W + IDX_W + BEAT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DW-1:0]      cpu_wdata,
    output logic [DW-1:0]      cpu_rdata,
    output logic               cpu_ack,
    output logic               mem_req,
    output logic               mem_we,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [MW-1:0]      mem_wdata,
    input  logic [MW-1:0]      mem_rdata,
    input  logic               mem_ack,
    output logic [CNT_W-1:0]   cnt_access,
    output logic [CNT_W-1:0]   cnt_hit,
    output logic [CNT_W-1:0]   cnt_miss,
    output logic [CNT_W-1:0]   cnt_fill,
    output logic [CNT_W-1:0]   cnt_wb
);
    import l1_cache_pkg::*;

    typedef struct packed {
        ctl_st_e          st;
        logic [BEAT_W-1:0] beat;
        logic [WAY_W-1:0] vic;
        logic             ack;
        logic [DW-1:0]    rdata;
        logic             retry;
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] hit;
        logic [CNT_W-1:0] miss;
        logic [CNT_W-1:0] fill;
        logic [CNT_W-1:0] wb;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [OFF_W-1:0] off;
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    assign off = cpu_addr[OFF_W-1:0];
    assign idx = cpu_addr[OFF_W +: IDX_W];
    assign tag = cpu_addr[ADDR_W-1 -: TAG_W];

    logic [WAYS-1:0]     hit_v, valid_v, dirty_v;
    logic [TAG_W-1:0]    tag_a  [WAYS];
    logic [WORDS*DW-1:0] line_a [WAYS];
    logic                any_hit;
    logic [WAY_W-1:0]    hit_way, victim;
    logic                wr_en, fill_en, fill_last, touch, fill_note;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        l1_way #(.DW(DW), .WORDS(WORDS), .SETS(SETS), .TAG_W(TAG_W), .BEATS(BEATS)) u_way (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (idx),
            .tag_i      (tag),
            .hit_o      (hit_v[w]),
            .valid_o    (valid_v[w]),
            .dirty_o    (dirty_v[w]),
            .tag_o      (tag_a[w]),
            .line_o     (line_a[w]),
            .wr_en_i    (wr_en && (hit_way == WAY_W'(w))),
            .wr_word_i  (off),
            .wr_data_i  (cpu_wdata),
            .fill_en_i  (fill_en && (ctl_q.vic == WAY_W'(w))),
            .fill_beat_i(ctl_q.beat),
            .fill_data_i(mem_rdata),
            .fill_last_i(fill_last)
        );
    end

    l1_repl #(.SETS(SETS), .WAYS(WAYS), .REPL(REPL)) u_repl (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (idx),
        .valid_i    (valid_v),
        .touch_i    (touch),
        .touch_way_i(hit_way),
        .fill_i     (fill_note),
        .victim_o   (victim)
    );

    always_comb begin
        any_hit = |hit_v;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_v[w]) hit_way = WAY_W'(w);
    end

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ack = 1'b0;
        wr_en     = 1'b0;
        fill_en   = 1'b0;
        fill_last = 1'b0;
        touch     = 1'b0;
        fill_note = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {tag, idx, ctl_q.beat};
        mem_wdata = line_a[ctl_q.vic][int'(ctl_q.beat) * MW +: MW];
        unique case (ctl_q.st)
            ST_IDLE: if (cpu_req) begin
                if (any_hit) begin
                    ctl_d.ack   = 1'b1;
                    ctl_d.rdata = line_a[hit_way][int'(off) * DW +: DW];
                    wr_en       = cpu_we;
                    touch       = 1'b1;
                    if (!ctl_q.retry) begin
                        ctl_d.acc = ctl_q.acc + 1'b1;
                        ctl_d.hit = ctl_q.hit + 1'b1;
                    end
                    ctl_d.retry = 1'b0;
                    ctl_d.st    = ST_HOLD;
                end else begin
                    ctl_d.acc  = ctl_q.acc + 1'b1;
                    ctl_d.miss = ctl_q.miss + 1'b1;
                    ctl_d.vic  = victim;
                    ctl_d.beat = '0;
                    ctl_d.st   = (valid_v[victim] && dirty_v[victim]) ? ST_WB : ST_FILL;
                end
            end
            ST_WB: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {tag_a[ctl_q.vic], idx, ctl_q.beat};
                if (mem_ack) begin
                    ctl_d.beat = ctl_q.beat + 1'b1;
                    if (ctl_q.beat == BEAT_W'(BEATS - 1)) begin
                        ctl_d.wb = ctl_q.wb + 1'b1;
                        ctl_d.st = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    fill_en    = 1'b1;
                    ctl_d.beat = ctl_q.beat + 1'b1;
                    if (ctl_q.beat == BEAT_W'(BEATS - 1)) begin
                        fill_last   = 1'b1;
                        fill_note   = 1'b1;
                        ctl_d.fill  = ctl_q.fill + 1'b1;
                        ctl_d.retry = 1'b1;
                        ctl_d.st    = ST_IDLE;
                    end
                end
            end
            default: if (!cpu_req) ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cpu_ack    = ctl_q.ack;
    assign cpu_rdata  = ctl_q.rdata;
    assign cnt_access = ctl_q.acc;
    assign cnt_hit    = ctl_q.hit;
    assign cnt_miss   = ctl_q.miss;
    assign cnt_fill   = ctl_q.fill;
    assign cnt_wb     = ctl_q.wb;

    // R2: the acknowledge lasts one clock
    a_r2_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    // R9: no acknowledge follows an edge where the request was low
    a_r9_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |=> !cpu_ack);

    // R3: a beat not yet accepted keeps its address
    a_r3_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R10: every counted access is either a hit or a miss
    a_r10_counts_balance: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(cnt_hit + cnt_miss) == cnt_access);

    // R6: a write-back beat is never issued while the processor is acknowledged
    a_r6_wb_not_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !cpu_ack);
endmodule

// File: tb/l1_cache_tb.sv
module l1_cache_tb;
    localparam int ADDR_W = 10, DW = 32, MW = 64, MADDR_W = 9, CNT_W = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0]  cpu_addr = '0;
    logic [DW-1:0]      cpu_wdata = '0;
    logic [DW-1:0]      cpu_rdata;
    logic               cpu_ack;
    logic               mem_req, mem_we, mem_ack;
    logic [MADDR_W-1:0] mem_addr;
    logic [MW-1:0]      mem_wdata, mem_rdata;
    logic [CNT_W-1:0]   cnt_access, cnt_hit, cnt_miss, cnt_fill, cnt_wb;

    always #2.5 clk = ~clk;

    l1_cache u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .cnt_access(cnt_access), .cnt_hit(cnt_hit), .cnt_miss(cnt_miss),
        .cnt_fill(cnt_fill), .cnt_wb(cnt_wb)
    );

    // next-level memory model, zero latency
    logic [MW-1:0] mem [2**MADDR_W];
    int            wr_beats = 0;
    int            rd_beats = 0;
    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_beats      <= wr_beats + 1;
        end
        if (mem_req && !mem_we) rd_beats <= rd_beats + 1;
    end

    logic [DW-1:0] shadow [2**ADDR_W];
    int checks = 0, errors = 0;
    int e_acc = 0, e_hit = 0, e_miss = 0, e_fill = 0, e_wb = 0;
    bit done = 1'b0;

    function automatic logic [DW-1:0] pat(int a);
        return 32'hC0DE_0000 ^ a;
    endfunction

    function automatic logic [ADDR_W-1:0] mk(int t, int s, int w);
        return {6'(t), 2'(s), 2'(w)};
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one processor access; hold = extra cycles the request stays high after ack
    task automatic access(bit we, logic [ADDR_W-1:0] a, logic [DW-1:0] d,
                          int exp_lat, string req, int hold = 0);
        int lat = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        forever begin
            @(posedge clk); @(negedge clk);
            lat++;
            if (cpu_ack || lat > 30) break;
        end
        check(lat == exp_lat, {req, " latency"}, lat, exp_lat);
        if (!we) check(cpu_rdata == shadow[a], {req, " data"}, cpu_rdata, shadow[a]);
        else     shadow[a] = d;
        e_acc++;
        if (exp_lat == 1) e_hit++;
        else begin e_miss++; e_fill++; end
        if (exp_lat == 6) e_wb++;
        for (int i = 0; i < hold; i++) begin
            @(posedge clk); @(negedge clk);
            check(!cpu_ack, "R9 no ack while held", cpu_ack, 0);
        end
        cpu_req = 1'b0;
        @(posedge clk); @(negedge clk);
        check(!cpu_ack, "R2 ack one clock", cpu_ack, 0);
    endtask

    task automatic t_reset();
        check(!cpu_ack && !mem_req, "R1 idle outputs", {cpu_ack, mem_req}, 0);
        check(cnt_access == 0 && cnt_hit == 0 && cnt_miss == 0 && cnt_fill == 0 && cnt_wb == 0,
              "R1 counters zero", cnt_access + cnt_hit + cnt_miss + cnt_fill + cnt_wb, 0);
    endtask

    task automatic t_read_miss_then_hit();
        access(1'b0, mk(1, 0, 2), '0, 4, "R3 load miss");
        check(rd_beats == 2, "R3 two fetch beats", rd_beats, 2);
        check(wr_beats == 0, "R7 no write on empty set", wr_beats, 0);
        access(1'b0, mk(1, 0, 1), '0, 1, "R2 load hit");
        access(1'b0, mk(1, 0, 3), '0, 1, "R2 load hit upper word");
    endtask

    task automatic t_store_hit();
        access(1'b1, mk(1, 0, 0), 32'h1234_5678, 1, "R4 store hit");
        access(1'b0, mk(1, 0, 0), '0, 1, "R4 read back");
        access(1'b0, mk(1, 0, 1), '0, 1, "R4 neighbour unchanged");
    endtask

    task automatic t_lru();
        access(1'b0, mk(2, 0, 0), '0, 4, "R8 invalid way filled");
        access(1'b0, mk(1, 0, 0), '0, 1, "R8 first line still resident");
        access(1'b0, mk(3, 0, 0), '0, 4, "R7 clean victim no writeback");
        check(wr_beats == 0, "R7 no memory write", wr_beats, 0);
        access(1'b0, mk(1, 0, 0), '0, 1, "R8 recent line kept");
        access(1'b0, mk(2, 0, 0), '0, 4, "R8 lru line evicted");
        check(wr_beats == 0, "R7 clean eviction", wr_beats, 0);
    endtask

    task automatic t_dirty_evict();
        logic [ADDR_W-1:0] d = mk(4, 1, 3);
        access(1'b1, d, 32'hDEAD_BEEF, 4, "R5 store miss allocate");
        access(1'b0, d, '0, 1, "R5 allocated word");
        access(1'b0, mk(5, 1, 0), '0, 4, "R8 second way of set");
        access(1'b0, mk(6, 1, 2), '0, 6, "R6 dirty victim");
        check(wr_beats == 2, "R6 full line written", wr_beats, 2);
        check(mem[d >> 1][d[0]*32 +: 32] == 32'hDEAD_BEEF, "R6 memory holds data",
              mem[d >> 1][d[0]*32 +: 32], 32'hDEAD_BEEF);
        check(mem[d >> 1][0 +: 32] == pat(int'(d) - 1), "R6 other word intact",
              mem[d >> 1][0 +: 32], pat(int'(d) - 1));
        access(1'b0, d, '0, 4, "R6 refetch written line");
    endtask

    task automatic t_hold();
        access(1'b0, d_hold(), '0, 1, "R9 held request", 3);
    endtask

    function automatic logic [ADDR_W-1:0] d_hold();
        return mk(4, 1, 3);
    endfunction

    task automatic t_counters();
        check(cnt_access == CNT_W'(e_acc), "R10 accesses", cnt_access, e_acc);
        check(cnt_hit == CNT_W'(e_hit), "R10 hits", cnt_hit, e_hit);
        check(cnt_miss == CNT_W'(e_miss), "R10 misses", cnt_miss, e_miss);
        check(cnt_fill == CNT_W'(e_fill), "R10 fills", cnt_fill, e_fill);
        check(cnt_wb == CNT_W'(e_wb), "R10 write-backs", cnt_wb, e_wb);
    endtask

    initial begin
        for (int i = 0; i < 2**MADDR_W; i++) mem[i] = {pat(2*i + 1), pat(2*i)};
        for (int i = 0; i < 2**ADDR_W; i++) shadow[i] = pat(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_miss_then_hit();
        t_store_hit();
        t_lru();
        t_dirty_evict();
        t_hold();
        t_counters();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule